// File: doc/BRIEF.md
# Packet Target to System Bus Bridge

This block sits between the receive and transmit streams of a serial-link endpoint and a simple single-word system-bus master port. It takes memory request packets from a 32-bit receive stream and decodes their three-word header. Each accepted request becomes one word access on the system bus. For every read, it builds a completion packet and sends it on the transmit stream. Payload words travel on the link in big-endian byte order, so the bridge reverses the bytes of every data word in both directions.

The host reaches the bus through a window of 2^ABITS bytes that is split in two halves. A write to the upper half stores the written word's bits [31:ABITS-1] in a page register and does not touch the bus. A read of the upper half returns that register. Any access to the lower half goes to the bus. Its address takes bits [31:ABITS-1] from the page register and bits [ABITS-2:0] from the request. The bridge handles one request at a time: it stops accepting receive words after a packet's last word and resumes once that request is fully served, including its completion.

Top module: `pkt_target_bridge`

## Requirements
- R1: In the cycle after synchronous reset is released, the outputs are as follows: rx_dst_rdy_n is 0, tx_src_rdy_n, tx_sof_n and tx_eof_n are 1, bus_req is 0 and ur_flag is 0.
- R2: A memory write packet is decoded from word 0. Its format bits [30:29] are 10, its type bits [28:24] are 00000 and its length bits [9:0] are 1. The address comes from word 2 bits [31:2]. When address bit ABITS-1 is 0, the packet causes exactly one bus write. The bus address is {page[31:ABITS-1], addr[ABITS-2:0]} and the bus data is word 3 byte-reversed.
- R3: A length-1 memory write with address bit ABITS-1 set causes no bus access. It loads the page register with bits [31:ABITS-1] of the byte-reversed word 3.
- R4: A length-1 memory read (format 00, type 00000) with address bit ABITS-1 clear causes one bus read at the mapped address. It is answered with a 4-word completion: word 0 is 0x4A000001 and word 3 is the bus read data byte-reversed.
- R5: A length-1 memory read with address bit ABITS-1 set causes no bus access. It is answered with a 4-word completion whose data word is {page, ABITS-1 zero bits} byte-reversed.
- R6: When the bus signals an error on a read, the completion has 3 words. Word 0 is 0x0A000000 and the status field (word 1 bits [15:13]) is 001.
- R7: A memory read or write whose length field is not 1 causes no bus access and no completion. It raises ur_flag for exactly one cycle.
- R8: A packet whose format/type is neither memory read nor memory write is consumed without bus access, completion or ur_flag.
- R9: After accepting a word with rx_eof_n low, the bridge holds rx_dst_rdy_n high until that request, including any completion, is finished. Gaps in rx_src_rdy_n within a packet are tolerated.
- R10: A completion starts only when tx_buf_av is non-zero. Its first word has tx_sof_n low together with tx_src_rdy_n, and its last word has tx_eof_n low. While tx_dst_rdy_n is high, the presented word and its flags stay unchanged.
- R11: Completion word 1 is {CPL_ID, status, 0, byte count 4}. Word 2 is {requester ID, tag, 0, address bits [6:0]}, where the requester ID and tag are copied from request word 1 bits [31:16] and [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 32 | Receive stream word |
| rx_sof_n | input | 1 | Receive first word marker, active low |
| rx_eof_n | input | 1 | Receive last word marker, active low |
| rx_src_rdy_n | input | 1 | Receive word valid, active low |
| rx_dst_rdy_n | output | 1 | Bridge ready for a receive word, active low |
| tx_data | output | 32 | Transmit stream word |
| tx_sof_n | output | 1 | Transmit first word marker, active low |
| tx_eof_n | output | 1 | Transmit last word marker, active low |
| tx_src_rdy_n | output | 1 | Transmit word valid, active low |
| tx_dst_rdy_n | input | 1 | Transmitter accepts word, active low |
| tx_buf_av | input | BUFW | Number of free transmit buffers |
| bus_req | output | 1 | Bus access request, held until ack |
| bus_we | output | 1 | Bus write when 1, read when 0 |
| bus_addr | output | 32 | Bus byte address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus access complete |
| bus_err | input | 1 | Bus access failed, valid with bus_ack |
| bus_rdata | input | 32 | Bus read data, valid with bus_ack |
| ur_flag | output | 1 | One-cycle pulse on a dropped bad-length request |

## Verification
A corrupted page register does not show until the next lower-half access or upper-half read, which then carries the wrong high bus address bits or completion data. A wrong header-capture slot or word count shows on the same request, as a wrong bus address, a misclassified packet or a completion missing its data word. A stuck handshake state shows within a cycle or two of the next packet's last word, as rx_dst_rdy_n never returning low or a completion that never starts or never ends.

// File: rtl/tgt_bridge_pkg.sv
package tgt_bridge_pkg;
  localparam int HDR_DW  = 3;
  localparam int PKT_MAX = HDR_DW + 1;
  localparam int PKT_IW  = $clog2(PKT_MAX);
  localparam int PKT_CW  = $clog2(PKT_MAX + 1);

  localparam logic [1:0] FMT_RD3   = 2'b00;
  localparam logic [1:0] FMT_WR3   = 2'b10;
  localparam logic [4:0] TYPE_MEM  = 5'b00000;
  localparam logic [4:0] TYPE_CPL  = 5'b01010;
  localparam logic [2:0] ST_OK     = 3'b000;
  localparam logic [2:0] ST_UNSUP  = 3'b001;
  localparam logic [11:0] BCNT_ONE = 12'd4;

  typedef enum logic [1:0] {K_OTHER, K_BADLEN, K_READ, K_WRITE} req_kind_e;

  typedef struct packed {
    req_kind_e   kind;
    logic [15:0] rid;
    logic [7:0]  tag;
    logic [31:0] addr;
    logic [31:0] data;
  } req_t;

  function automatic logic [31:0] byte_rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/tgt_rx_parse.sv
module tgt_rx_parse
  import tgt_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] rx_data,
  input  logic        rx_sof_n,
  input  logic        rx_eof_n,
  input  logic        rx_src_rdy_n,
  output logic        rx_dst_rdy_n,
  output logic        req_valid,
  output req_t        req,
  input  logic        req_done
);
  logic [PKT_MAX-1:0][31:0] slot;
  logic [PKT_CW-1:0]        wcnt;
  logic                     in_pkt;
  logic                     hold;
  logic                     take;
  logic [1:0]               fmt;
  logic [4:0]               typ;
  logic [9:0]               len;
  logic                     is_mem;

  assign take = !rx_src_rdy_n && !rx_dst_rdy_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt       <= 1'b0;
      hold         <= 1'b0;
      rx_dst_rdy_n <= 1'b0;
      wcnt         <= '0;
      slot         <= '0;
    end else if (hold) begin
      if (req_done) begin
        hold         <= 1'b0;
        rx_dst_rdy_n <= 1'b0;
      end
    end else if (take) begin
      if (!rx_sof_n) begin
        slot[0] <= rx_data;
        wcnt    <= PKT_CW'(1);
        in_pkt  <= 1'b1;
      end else if (in_pkt && (wcnt < PKT_CW'(PKT_MAX))) begin
        slot[wcnt[PKT_IW-1:0]] <= rx_data;
        wcnt <= wcnt + PKT_CW'(1);
      end
      if ((!rx_sof_n || in_pkt) && !rx_eof_n) begin
        in_pkt       <= 1'b0;
        hold         <= 1'b1;
        rx_dst_rdy_n <= 1'b1;
      end
    end
  end

  assign fmt    = slot[0][30:29];
  assign typ    = slot[0][28:24];
  assign len    = slot[0][9:0];
  assign is_mem = (typ == TYPE_MEM) && (wcnt >= PKT_CW'(HDR_DW)) &&
                  ((fmt == FMT_RD3) || ((fmt == FMT_WR3) && (wcnt >= PKT_CW'(PKT_MAX))));

  always_comb begin
    req.rid  = slot[1][31:16];
    req.tag  = slot[1][15:8];
    req.addr = {slot[2][31:2], 2'b00};
    req.data = slot[HDR_DW];
    if (!is_mem)             req.kind = K_OTHER;
    else if (len != 10'd1)   req.kind = K_BADLEN;
    else if (fmt == FMT_WR3) req.kind = K_WRITE;
    else                     req.kind = K_READ;
  end

  assign req_valid = hold;
endmodule

// File: rtl/tgt_addr_win.sv
module tgt_addr_win #(
  parameter int ABITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ABITS-1:0] win_off,
  input  logic             page_we,
  input  logic [32-ABITS:0] page_in,
  output logic             upper,
  output logic [31:0]      map_addr,
  output logic [31:0]      page_word
);
  localparam int PW = 33 - ABITS;
  localparam int LW = ABITS - 1;

  logic [PW-1:0] page_q;

  always_ff @(posedge clk) begin
    if (rst)          page_q <= '0;
    else if (page_we) page_q <= page_in;
  end

  assign upper     = win_off[ABITS-1];
  assign map_addr  = {page_q, win_off[LW-1:0]};
  assign page_word = {page_q, {LW{1'b0}}};
endmodule

// File: rtl/tgt_engine.sv
module tgt_engine
  import tgt_bridge_pkg::*;
#(
  parameter logic [15:0] CPL_ID = 16'h0100
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  req_t                     req,
  output logic                     req_done,
  input  logic                     upper,
  input  logic [31:0]              map_addr,
  input  logic [31:0]              page_word,
  output logic                     page_we,
  output logic                     bus_req,
  output logic                     bus_we,
  output logic [31:0]              bus_addr,
  output logic [31:0]              bus_wdata,
  input  logic                     bus_ack,
  input  logic                     bus_err,
  input  logic [31:0]              bus_rdata,
  output logic                     cpl_start,
  output logic [PKT_MAX-1:0][31:0] cpl_words,
  output logic [PKT_IW-1:0]        cpl_last,
  input  logic                     cpl_done,
  output logic                     ur_flag
);
  typedef enum logic [2:0] {S_IDLE, S_BUS, S_CPL, S_TXW, S_DONE} eng_st_e;

  eng_st_e     st;
  logic [31:0] rd_le;
  logic        rd_bad;

  assign page_we = (st == S_IDLE) && req_valid && (req.kind == K_WRITE) && upper;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      req_done  <= 1'b0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cpl_start <= 1'b0;
      ur_flag   <= 1'b0;
      rd_le     <= '0;
      rd_bad    <= 1'b0;
    end else begin
      ur_flag <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          case (req.kind)
            K_WRITE: begin
              if (upper) begin
                req_done <= 1'b1;
                st       <= S_DONE;
              end else begin
                bus_req   <= 1'b1;
                bus_we    <= 1'b1;
                bus_addr  <= map_addr;
                bus_wdata <= byte_rev(req.data);
                st        <= S_BUS;
              end
            end
            K_READ: begin
              if (upper) begin
                rd_le  <= page_word;
                rd_bad <= 1'b0;
                st     <= S_CPL;
              end else begin
                bus_req  <= 1'b1;
                bus_we   <= 1'b0;
                bus_addr <= map_addr;
                st       <= S_BUS;
              end
            end
            K_BADLEN: begin
              ur_flag  <= 1'b1;
              req_done <= 1'b1;
              st       <= S_DONE;
            end
            default: begin
              req_done <= 1'b1;
              st       <= S_DONE;
            end
          endcase
        end
        S_BUS: if (bus_ack) begin
          bus_req <= 1'b0;
          if (bus_we) begin
            req_done <= 1'b1;
            st       <= S_DONE;
          end else begin
            rd_le  <= bus_rdata;
            rd_bad <= bus_err;
            st     <= S_CPL;
          end
        end
        S_CPL: begin
          cpl_start <= 1'b1;
          st        <= S_TXW;
        end
        S_TXW: begin
          cpl_start <= 1'b0;
          if (cpl_done) begin
            req_done <= 1'b1;
            st       <= S_DONE;
          end
        end
        default: begin
          req_done <= 1'b0;
          st       <= S_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    cpl_words[0] = rd_bad ? {1'b0, FMT_RD3, TYPE_CPL, 24'h000000}
                          : {1'b0, FMT_WR3, TYPE_CPL, 24'h000001};
    cpl_words[1] = {CPL_ID, (rd_bad ? ST_UNSUP : ST_OK), 1'b0, BCNT_ONE};
    cpl_words[2] = {req.rid, req.tag, 1'b0, req.addr[6:0]};
    cpl_words[3] = byte_rev(rd_le);
    cpl_last     = rd_bad ? PKT_IW'(HDR_DW - 1) : PKT_IW'(HDR_DW);
  end
endmodule

// File: rtl/tgt_cpl_tx.sv
module tgt_cpl_tx
  import tgt_bridge_pkg::*;
#(
  parameter int BUFW = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [PKT_MAX-1:0][31:0] words,
  input  logic [PKT_IW-1:0]        last_idx,
  input  logic [BUFW-1:0]          tx_buf_av,
  input  logic                     tx_dst_rdy_n,
  output logic [31:0]              tx_data,
  output logic                     tx_sof_n,
  output logic                     tx_eof_n,
  output logic                     tx_src_rdy_n,
  output logic                     done
);
  typedef enum logic [1:0] {T_IDLE, T_WAIT, T_SEND} tx_st_e;

  tx_st_e            st;
  logic [PKT_IW-1:0] idx;
  logic [PKT_IW-1:0] nxt;

  assign nxt = idx + PKT_IW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= T_IDLE;
      idx          <= '0;
      tx_data      <= '0;
      tx_sof_n     <= 1'b1;
      tx_eof_n     <= 1'b1;
      tx_src_rdy_n <= 1'b1;
      done         <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        T_IDLE: if (start) st <= T_WAIT;
        T_WAIT: if (tx_buf_av != '0) begin
          tx_data      <= words[0];
          tx_sof_n     <= 1'b0;
          tx_src_rdy_n <= 1'b0;
          tx_eof_n     <= (last_idx != '0);
          idx          <= '0;
          st           <= T_SEND;
        end
        default: if (!tx_dst_rdy_n) begin
          if (idx == last_idx) begin
            tx_src_rdy_n <= 1'b1;
            tx_sof_n     <= 1'b1;
            tx_eof_n     <= 1'b1;
            done         <= 1'b1;
            st           <= T_IDLE;
          end else begin
            idx      <= nxt;
            tx_data  <= words[nxt];
            tx_sof_n <= 1'b1;
            tx_eof_n <= (nxt != last_idx);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pkt_target_bridge.sv
module pkt_target_bridge
  import tgt_bridge_pkg::*;
#(
  parameter int          ABITS  = 16,
  parameter int          BUFW   = 6,
  parameter logic [15:0] CPL_ID = 16'h0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [31:0]     rx_data,
  input  logic            rx_sof_n,
  input  logic            rx_eof_n,
  input  logic            rx_src_rdy_n,
  output logic            rx_dst_rdy_n,
  output logic [31:0]     tx_data,
  output logic            tx_sof_n,
  output logic            tx_eof_n,
  output logic            tx_src_rdy_n,
  input  logic            tx_dst_rdy_n,
  input  logic [BUFW-1:0] tx_buf_av,
  output logic            bus_req,
  output logic            bus_we,
  output logic [31:0]     bus_addr,
  output logic [31:0]     bus_wdata,
  input  logic            bus_ack,
  input  logic            bus_err,
  input  logic [31:0]     bus_rdata,
  output logic            ur_flag
);
  logic                     req_valid;
  req_t                     req;
  logic                     req_done;
  logic                     upper;
  logic [31:0]              map_addr;
  logic [31:0]              page_word;
  logic                     page_we;
  logic [31:0]              wr_le;
  logic                     cpl_start;
  logic [PKT_MAX-1:0][31:0] cpl_words;
  logic [PKT_IW-1:0]        cpl_last;
  logic                     cpl_done;

  assign wr_le = byte_rev(req.data);

  tgt_rx_parse u_rx (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_sof_n(rx_sof_n),
    .rx_eof_n(rx_eof_n), .rx_src_rdy_n(rx_src_rdy_n), .rx_dst_rdy_n(rx_dst_rdy_n),
    .req_valid(req_valid), .req(req), .req_done(req_done)
  );

  tgt_addr_win #(.ABITS(ABITS)) u_win (
    .clk(clk), .rst(rst), .win_off(req.addr[ABITS-1:0]), .page_we(page_we),
    .page_in(wr_le[31:ABITS-1]), .upper(upper), .map_addr(map_addr),
    .page_word(page_word)
  );

  tgt_engine #(.CPL_ID(CPL_ID)) u_eng (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req(req), .req_done(req_done),
    .upper(upper), .map_addr(map_addr), .page_word(page_word), .page_we(page_we),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .cpl_start(cpl_start), .cpl_words(cpl_words), .cpl_last(cpl_last),
    .cpl_done(cpl_done), .ur_flag(ur_flag)
  );

  tgt_cpl_tx #(.BUFW(BUFW)) u_tx (
    .clk(clk), .rst(rst), .start(cpl_start), .words(cpl_words), .last_idx(cpl_last),
    .tx_buf_av(tx_buf_av), .tx_dst_rdy_n(tx_dst_rdy_n), .tx_data(tx_data),
    .tx_sof_n(tx_sof_n), .tx_eof_n(tx_eof_n), .tx_src_rdy_n(tx_src_rdy_n),
    .done(cpl_done)
  );
endmodule

// File: rtl/pkt_target_bridge_chk.sv
module pkt_target_bridge_chk #(
  parameter int BUFW = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_sof_n,
  input logic            rx_eof_n,
  input logic            rx_src_rdy_n,
  input logic            rx_dst_rdy_n,
  input logic [31:0]     tx_data,
  input logic            tx_sof_n,
  input logic            tx_eof_n,
  input logic            tx_src_rdy_n,
  input logic            tx_dst_rdy_n,
  input logic [BUFW-1:0] tx_buf_av,
  input logic            bus_req,
  input logic            bus_we,
  input logic [31:0]     bus_addr,
  input logic            bus_ack,
  input logic            ur_flag
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bus_req && tx_src_rdy_n && !rx_dst_rdy_n && !ur_flag));

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R7
  ur_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ur_flag |=> !ur_flag);

  // R9
  rx_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_src_rdy_n && !rx_dst_rdy_n && !rx_eof_n) |=> rx_dst_rdy_n);

  // R10
  tx_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_src_rdy_n) |-> (!tx_sof_n && ($past(tx_buf_av) != '0)));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_src_rdy_n && tx_dst_rdy_n) |=>
      (!tx_src_rdy_n && $stable(tx_data) && $stable(tx_sof_n) && $stable(tx_eof_n)));

  // R10
  tx_idle_flags_chk: assert property (@(posedge clk) disable iff (rst)
    tx_src_rdy_n |-> (tx_sof_n && tx_eof_n));
endmodule

bind pkt_target_bridge pkt_target_bridge_chk #(.BUFW(BUFW)) u_chk (
  .clk(clk), .rst(rst), .rx_sof_n(rx_sof_n), .rx_eof_n(rx_eof_n),
  .rx_src_rdy_n(rx_src_rdy_n), .rx_dst_rdy_n(rx_dst_rdy_n), .tx_data(tx_data),
  .tx_sof_n(tx_sof_n), .tx_eof_n(tx_eof_n), .tx_src_rdy_n(tx_src_rdy_n),
  .tx_dst_rdy_n(tx_dst_rdy_n), .tx_buf_av(tx_buf_av), .bus_req(bus_req),
  .bus_we(bus_we), .bus_addr(bus_addr), .bus_ack(bus_ack), .ur_flag(ur_flag)
);

// File: tb/pkt_target_bridge_tb_top.sv
`timescale 1ns/1ps
module pkt_target_bridge_tb_top;
  localparam int          ABITS  = 16;
  localparam int          BUFW   = 6;
  localparam logic [15:0] CPL_ID = 16'h0100;
  localparam logic [31:0] BAR    = 32'hF000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] rx_data = '0;
  logic rx_sof_n = 1'b1, rx_eof_n = 1'b1, rx_src_rdy_n = 1'b1;
  logic rx_dst_rdy_n;
  logic [31:0] tx_data;
  logic tx_sof_n, tx_eof_n, tx_src_rdy_n;
  logic tx_dst_rdy_n = 1'b0;
  logic [BUFW-1:0] tx_buf_av = 6'd4;
  logic bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic bus_ack = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic ur_flag;

  int checks = 0, failures = 0;
  int wr_cnt = 0, rd_cnt = 0, ur_cnt = 0;
  logic [31:0] last_wa, last_wd, last_ra;
  int bus_lat = 1;
  logic err_mode = 1'b0;
  logic [31:0] rd_val = 32'hA1B2_C3D4;
  logic [31:0] pk [0:4];
  logic [31:0] cw [0:3];
  int cn;
  bit done_flag = 0;

  always #4 clk = ~clk;

  pkt_target_bridge #(.ABITS(ABITS), .BUFW(BUFW), .CPL_ID(CPL_ID)) dut_i (
    .clk(clk), .rst(rst), .rx_data(rx_data), .rx_sof_n(rx_sof_n), .rx_eof_n(rx_eof_n),
    .rx_src_rdy_n(rx_src_rdy_n), .rx_dst_rdy_n(rx_dst_rdy_n), .tx_data(tx_data),
    .tx_sof_n(tx_sof_n), .tx_eof_n(tx_eof_n), .tx_src_rdy_n(tx_src_rdy_n),
    .tx_dst_rdy_n(tx_dst_rdy_n), .tx_buf_av(tx_buf_av), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .ur_flag(ur_flag)
  );

  function automatic logic [31:0] rev(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic [31:0] hdr0(input logic [1:0] f, input logic [4:0] t, input logic [9:0] l);
    return {1'b0, f, t, 14'd0, l};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bus slave model and ur pulse counter
  initial begin
    int lc;
    lc = 0;
    forever begin
      @(negedge clk);
      if (ur_flag) ur_cnt++;
      if (bus_ack) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
      end else if (bus_req) begin
        if (lc >= bus_lat) begin
          bus_ack   = 1'b1;
          bus_err   = err_mode;
          bus_rdata = rd_val;
          if (bus_we) begin wr_cnt++; last_wa = bus_addr; last_wd = bus_wdata; end
          else begin rd_cnt++; last_ra = bus_addr; end
          lc = 0;
        end else lc++;
      end
    end
  end

  task automatic send_pkt(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 2 == 1)) begin
        rx_src_rdy_n = 1'b1;
        @(negedge clk);
      end
      rx_data      = pk[i];
      rx_sof_n     = (i == 0) ? 1'b0 : 1'b1;
      rx_eof_n     = (i == n - 1) ? 1'b0 : 1'b1;
      rx_src_rdy_n = 1'b0;
      while (rx_dst_rdy_n) @(negedge clk);
      @(negedge clk);
    end
    rx_src_rdy_n = 1'b1;
    rx_sof_n     = 1'b1;
    rx_eof_n     = 1'b1;
  endtask

  task automatic get_cpl(input bit thr, input string req);
    int t;
    bit fin;
    t = 0; fin = 0; cn = 0;
    while (!fin && t < 2000) begin
      tx_dst_rdy_n = (thr && (t % 3 == 1)) ? 1'b1 : 1'b0;
      if (!tx_src_rdy_n && !tx_dst_rdy_n) begin
        if (cn < 4) cw[cn] = tx_data;
        chk((tx_sof_n == 1'b0) == (cn == 0), "R10 sof position", 32'(tx_sof_n), 32'(cn != 0));
        cn++;
        if (!tx_eof_n) fin = 1;
      end
      @(negedge clk);
      t++;
    end
    tx_dst_rdy_n = 1'b0;
    chk(fin, req, 32'(fin), 32'd1);
  endtask

  task automatic no_cpl(input int cyc, input string req);
    bit seen;
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      if (!tx_src_rdy_n) seen = 1;
      @(negedge clk);
    end
    chk(!seen, req, 32'(seen), 32'd0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!rx_dst_rdy_n && tx_src_rdy_n && tx_sof_n && tx_eof_n && !bus_req && !ur_flag,
        "R1 reset outputs",
        {26'd0, rx_dst_rdy_n, tx_src_rdy_n, tx_sof_n, tx_eof_n, bus_req, ur_flag}, 32'h1C);
  endtask

  task automatic t_page();
    int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    pk[0] = hdr0(2'b10, 5'd0, 10'd1); pk[1] = 32'hABCD_110F;
    pk[2] = BAR | 32'h8000;            pk[3] = 32'h0080_6745;
    send_pkt(4, 0);
    no_cpl(12, "R3 page write sends nothing");
    chk(wr_cnt == w0, "R3 page write no bus", 32'(wr_cnt), 32'(w0));
    pk[0] = hdr0(2'b00, 5'd0, 10'd1); pk[1] = 32'h0203_220F; pk[2] = BAR | 32'h8010;
    send_pkt(3, 0);
    get_cpl(0, "R5 upper read completes");
    chk(cn == 4, "R5 word count", 32'(cn), 32'd4);
    chk(cw[3] == 32'h0080_6745, "R5 page readback", cw[3], 32'h0080_6745);
    chk(cw[2] == 32'h0203_2210, "R11 rid/tag/lower addr", cw[2], 32'h0203_2210);
    chk(rd_cnt == r0, "R5 no bus read", 32'(rd_cnt), 32'(r0));
  endtask

  task automatic t_lower_write();
    int w0;
    w0 = wr_cnt;
    pk[0] = hdr0(2'b10, 5'd0, 10'd1); pk[1] = 32'h0001_330F;
    pk[2] = BAR | 32'h0124;            pk[3] = 32'h1122_3344;
    send_pkt(4, 1);
    for (int i = 0; i < 40 && wr_cnt == w0; i++) @(negedge clk);
    chk(wr_cnt == w0 + 1, "R2 one bus write", 32'(wr_cnt), 32'(w0 + 1));
    chk(last_wa == 32'h4567_8124, "R2 mapped address", last_wa, 32'h4567_8124);
    chk(last_wd == 32'h4433_2211, "R2 byte reversed data", last_wd, 32'h4433_2211);
    repeat (4) @(negedge clk);
    chk(!rx_dst_rdy_n, "R9 ready again after write", 32'(rx_dst_rdy_n), 32'd0);
  endtask

  task automatic t_lower_read();
    bus_lat = 3;
    pk[0] = hdr0(2'b00, 5'd0, 10'd1); pk[1] = 32'hBEEF_5A0F; pk[2] = BAR | 32'h00F8;
    send_pkt(3, 1);
    get_cpl(1, "R4 read completes");
    chk(last_ra == 32'h4567_80F8, "R4 bus read address", last_ra, 32'h4567_80F8);
    chk(cn == 4, "R4 word count", 32'(cn), 32'd4);
    chk(cw[0] == 32'h4A00_0001, "R4 header word 0", cw[0], 32'h4A00_0001);
    chk(cw[1] == {CPL_ID, 16'h0004}, "R11 completer word", cw[1], {CPL_ID, 16'h0004});
    chk(cw[2] == 32'hBEEF_5A78, "R11 rid/tag/lower addr", cw[2], 32'hBEEF_5A78);
    chk(cw[3] == 32'hD4C3_B2A1, "R4 data byte reversed", cw[3], 32'hD4C3_B2A1);
    bus_lat = 1;
  endtask

  task automatic t_read_err();
    err_mode = 1'b1;
    pk[0] = hdr0(2'b00, 5'd0, 10'd1); pk[1] = 32'h7777_010F; pk[2] = BAR | 32'h0040;
    send_pkt(3, 0);
    get_cpl(0, "R6 error read completes");
    err_mode = 1'b0;
    chk(cn == 3, "R6 word count", 32'(cn), 32'd3);
    chk(cw[0] == 32'h0A00_0000, "R6 header word 0", cw[0], 32'h0A00_0000);
    chk(cw[1] == {CPL_ID, 16'h2004}, "R6 status field", cw[1], {CPL_ID, 16'h2004});
  endtask

  task automatic t_badlen();
    int w0, r0, u0;
    w0 = wr_cnt; r0 = rd_cnt; u0 = ur_cnt;
    pk[0] = hdr0(2'b10, 5'd0, 10'd2); pk[1] = 32'h0001_440F;
    pk[2] = BAR | 32'h0010; pk[3] = 32'h0102_0304; pk[4] = 32'h0506_0708;
    send_pkt(5, 0);
    no_cpl(15, "R7 bad write no completion");
    chk(ur_cnt == u0 + 1, "R7 ur pulse on write", 32'(ur_cnt), 32'(u0 + 1));
    pk[0] = hdr0(2'b00, 5'd0, 10'd4); pk[1] = 32'h0001_450F; pk[2] = BAR | 32'h0020;
    send_pkt(3, 0);
    no_cpl(15, "R7 bad read no completion");
    chk(ur_cnt == u0 + 2, "R7 ur pulse on read", 32'(ur_cnt), 32'(u0 + 2));
    chk(wr_cnt == w0 && rd_cnt == r0, "R7 no bus access", 32'(wr_cnt + rd_cnt), 32'(w0 + r0));
  endtask

  task automatic t_other();
    int w0, r0, u0;
    w0 = wr_cnt; r0 = rd_cnt; u0 = ur_cnt;
    pk[0] = hdr0(2'b10, 5'b00100, 10'd1); pk[1] = 32'h0001_460F;
    pk[2] = BAR | 32'h0030;                pk[3] = 32'hDEAD_BEEF;
    send_pkt(4, 0);
    no_cpl(15, "R8 no completion");
    chk(ur_cnt == u0, "R8 no ur pulse", 32'(ur_cnt), 32'(u0));
    chk(wr_cnt == w0 && rd_cnt == r0, "R8 no bus access", 32'(wr_cnt + rd_cnt), 32'(w0 + r0));
    chk(!rx_dst_rdy_n, "R8 ready for next packet", 32'(rx_dst_rdy_n), 32'd0);
  endtask

  task automatic t_bufgate();
    tx_buf_av = '0;
    pk[0] = hdr0(2'b00, 5'd0, 10'd1); pk[1] = 32'h0A0B_770F; pk[2] = BAR | 32'h0004;
    send_pkt(3, 0);
    no_cpl(40, "R10 no start without buffer");
    chk(rx_dst_rdy_n, "R9 receive stalled while busy", 32'(rx_dst_rdy_n), 32'd1);
    tx_buf_av = 6'd3;
    get_cpl(0, "R10 starts once buffer free");
    chk(cn == 4, "R10 word count", 32'(cn), 32'd4);
    repeat (4) @(negedge clk);
    chk(!rx_dst_rdy_n, "R9 ready after completion", 32'(rx_dst_rdy_n), 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_page();
    t_lower_write();
    t_lower_read();
    t_read_err();
    t_badlen();
    t_other();
    t_bufgate();
    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule